// File: doc/BRIEF.md
# Raster-Operation Block Transfer Engine

This engine moves a rectangle of pixels from a source surface to a destination surface through a single 32-bit word memory port. For every destination pixel it reads a source pixel and the current destination pixel, and takes a pattern pixel from an 8x8 monochrome pattern. It merges the three with any of the 256 three-operand raster operations and writes the result back.

The source can hold color pixels of 8, 16 or 32 bits, or it can be a 1-bit-per-pixel bitmap that is expanded to the foreground and background colors. A transparent mode skips each destination write whose source pixel equals a key color. When the two rectangles overlap, the engine picks the traversal direction from the two base addresses, so every source pixel is read before it is overwritten.

A controller sets up the operation registers, pulses `start`, and waits for `done`. All configuration is captured when `start` is accepted. Later changes to the inputs do not affect an operation that is already running.

Top module: `blit_engine`

## Requirements
- R1: Result bit i is bit number {P[i],S[i],D[i]} of `ropCode`, with the pattern bit as the most significant index bit and the destination bit as the least. So 8'hCC copies the source, 8'hF0 copies the pattern and 8'hAA keeps the destination.
- R2: The pattern pixel for rectangle-relative coordinates (x, y) comes from `patBits` bit index (y mod 8)*8 + (x mod 8). A 1 selects `fgColor` and a 0 selects `bgColor`.
- R3: `depthSel` selects the pixel size: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. Pixels are little-endian. The pixel at byte address A sits in lanes starting at A mod 4, and only its bytes are enabled on a write.
- R4: With `monoSrc` set, source pixel x of row y is bit (x mod 8) of byte `srcBase + y*srcPitch + x/8`, counted from the least significant bit. It expands to `fgColor` when 1 and `bgColor` when 0, cut to the pixel size.
- R5: With `transparent` set, a pixel whose source value (after expansion and cut to the pixel size) equals `keyColor` cut to the pixel size is not written. All other pixels are written. With `transparent` clear, every pixel is written.
- R6: When `dstBase` > `srcBase`, rows are processed from last to first and pixels within a row from right to left. Otherwise the order is first row first, left to right. Each pixel's reads and write complete before the next pixel starts.
- R7: `busy` rises the cycle after an accepted `start`, and `done` clears at that point. `done` rises after the last write, stays high until the next accepted start, and is never high together with `busy`. A `start` while busy is ignored, and so are input changes during an operation.
- R8: A width or height of zero performs no memory access and raises `done` one cycle after `start`.
- R9: Each pixel costs one source read, one destination read and, unless skipped, one write, in that order. `memValid` and the address and control stay constant until `memReady`. Every address is word-aligned, and read data is taken in the cycle where `memValid` and `memReady` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted when idle |
| srcBase | input | 32 | Source byte address of the top-left pixel |
| dstBase | input | 32 | Destination byte address of the top-left pixel |
| srcPitch | input | 16 | Source row stride in bytes |
| dstPitch | input | 16 | Destination row stride in bytes |
| width | input | 12 | Rectangle width in pixels |
| height | input | 12 | Rectangle height in rows |
| depthSel | input | 2 | Pixel size code |
| ropCode | input | 8 | Three-operand raster operation |
| monoSrc | input | 1 | Source is a 1-bit bitmap |
| transparent | input | 1 | Skip writes whose source matches the key |
| fgColor | input | 32 | Foreground color for expansion |
| bgColor | input | 32 | Background color for expansion |
| keyColor | input | 32 | Transparency key |
| patBits | input | 64 | 8x8 monochrome pattern |
| memValid | output | 1 | Memory request valid |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Byte enables (all ones on reads) |
| memReady | input | 1 | Memory accepts the request |
| memRdata | input | 32 | Read data, valid with memReady |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished |

## Verification
The assertions assume that `memReady` is only meaningful while `memValid` is high. They also assume that color-mode base addresses and pitches are multiples of the pixel size, so each pixel fits inside one word. The stimulus keeps every surface within a 1 KB memory model, sizes the pitches to match the pixel size, and drives `memReady` from a free-running shift register so that stalls land on all three access kinds. The expected memory image comes from a byte-level model that applies the requirements in the traversal order given by R6.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W = WORD_W / 8;

  localparam logic [1:0] DEPTH_8 = 2'd0;
  localparam logic [1:0] DEPTH_16 = 2'd1;

  typedef enum logic [1:0] {
    PH_SRC = 2'd0,
    PH_DST = 2'd1,
    PH_WR = 2'd2
  } phase_e;

  typedef struct packed {
    logic latchCfg;
    logic capSrc;
    logic capDst;
    phase_e phase;
  } dp_ctrl_t;

  function automatic logic [WORD_W-1:0] ropApply(
    input logic [7:0] code,
    input logic [WORD_W-1:0] pat,
    input logic [WORD_W-1:0] src,
    input logic [WORD_W-1:0] dst
  );
    logic [WORD_W-1:0] res;
    for (int i = 0; i < WORD_W; i++) begin
      res[i] = code[{pat[i], src[i], dst[i]}];
    end
    return res;
  endfunction
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic              memReady,
  input  logic              skipWrite,
  output logic              memValid,
  output logic              memWe,
  output logic [DIM_W-1:0]  xPos,
  output logic [DIM_W-1:0]  yPos,
  output dp_ctrl_t          dpCtrl,
  output logic              busy,
  output logic              done
);
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_RSRC, S_RDST, S_WR} state_e;

  state_e state;
  logic [DIM_W-1:0] wReg, hReg;
  logic rev, revNow, lastX, lastY, advance;

  assign revNow = dstBase > srcBase;
  assign lastX = rev ? (xPos == '0) : (xPos == wReg - ONE);
  assign lastY = rev ? (yPos == '0) : (yPos == hReg - ONE);
  assign advance = (state == S_WR) && (skipWrite || memReady);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      wReg <= '0;
      hReg <= '0;
      xPos <= '0;
      yPos <= '0;
      rev <= 1'b0;
      done <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            wReg <= width;
            hReg <= height;
            rev <= revNow;
            xPos <= revNow ? width - ONE : '0;
            yPos <= revNow ? height - ONE : '0;
            if (width == '0 || height == '0) begin
              done <= 1'b1;
            end else begin
              done <= 1'b0;
              state <= S_RSRC;
            end
          end
        end
        S_RSRC: if (memReady) state <= S_RDST;
        S_RDST: if (memReady) state <= S_WR;
        S_WR: begin
          if (advance) begin
            if (lastX) begin
              if (lastY) begin
                state <= S_IDLE;
                done <= 1'b1;
              end else begin
                yPos <= rev ? yPos - ONE : yPos + ONE;
                xPos <= rev ? wReg - ONE : '0;
                state <= S_RSRC;
              end
            end else begin
              xPos <= rev ? xPos - ONE : xPos + ONE;
              state <= S_RSRC;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = state != S_IDLE;
  assign memValid = (state == S_RSRC) || (state == S_RDST) || ((state == S_WR) && !skipWrite);
  assign memWe = state == S_WR;

  always_comb begin
    dpCtrl.latchCfg = (state == S_IDLE) && start;
    dpCtrl.capSrc = (state == S_RSRC) && memReady;
    dpCtrl.capDst = (state == S_RDST) && memReady;
    dpCtrl.phase = (state == S_RSRC) ? PH_SRC : (state == S_WR) ? PH_WR : PH_DST;
  end
endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W = 12,
  parameter int PITCH_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dp_ctrl_t            dpCtrl,
  input  logic [DIM_W-1:0]    xPos,
  input  logic [DIM_W-1:0]    yPos,
  input  logic [ADDR_W-1:0]   srcBase,
  input  logic [ADDR_W-1:0]   dstBase,
  input  logic [PITCH_W-1:0]  srcPitch,
  input  logic [PITCH_W-1:0]  dstPitch,
  input  logic [1:0]          depthSel,
  input  logic [7:0]          ropCode,
  input  logic                monoSrc,
  input  logic                transparent,
  input  logic [WORD_W-1:0]   fgColor,
  input  logic [WORD_W-1:0]   bgColor,
  input  logic [WORD_W-1:0]   keyColor,
  input  logic [63:0]         patBits,
  input  logic [WORD_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memWdata,
  output logic [BE_W-1:0]     memBe,
  output logic                skipWrite
);
  logic [ADDR_W-1:0] sBase, dBase;
  logic [PITCH_W-1:0] sPitch, dPitch;
  logic [1:0] depth;
  logic [7:0] rop;
  logic mono, transp;
  logic [WORD_W-1:0] fg, bg, key;
  logic [63:0] pat;
  logic [WORD_W-1:0] srcPix, dstPix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sBase <= '0;
      dBase <= '0;
      sPitch <= '0;
      dPitch <= '0;
      depth <= DEPTH_8;
      rop <= '0;
      mono <= 1'b0;
      transp <= 1'b0;
      fg <= '0;
      bg <= '0;
      key <= '0;
      pat <= '0;
    end else if (dpCtrl.latchCfg) begin
      sBase <= srcBase;
      dBase <= dstBase;
      sPitch <= srcPitch;
      dPitch <= dstPitch;
      depth <= depthSel;
      rop <= ropCode;
      mono <= monoSrc;
      transp <= transparent;
      fg <= fgColor;
      bg <= bgColor;
      key <= keyColor;
      pat <= patBits;
    end
  end

  logic [1:0] shAmt;
  logic [WORD_W-1:0] pixMask;
  logic [BE_W-1:0] beBase;

  always_comb begin
    case (depth)
      DEPTH_8: begin shAmt = 2'd0; pixMask = WORD_W'(8'hFF); beBase = BE_W'(4'b0001); end
      DEPTH_16: begin shAmt = 2'd1; pixMask = WORD_W'(16'hFFFF); beBase = BE_W'(4'b0011); end
      default: begin shAmt = 2'd2; pixMask = '1; beBase = '1; end
    endcase
  end

  logic [ADDR_W-1:0] srcRow, dstRow, srcOff, srcByte, dstByte;

  assign srcRow = sBase + ADDR_W'(yPos) * ADDR_W'(sPitch);
  assign dstRow = dBase + ADDR_W'(yPos) * ADDR_W'(dPitch);
  assign srcOff = mono ? ADDR_W'(xPos >> 3) : (ADDR_W'(xPos) << shAmt);
  assign srcByte = srcRow + srcOff;
  assign dstByte = dstRow + (ADDR_W'(xPos) << shAmt);

  assign memAddr = (dpCtrl.phase == PH_SRC) ? {srcByte[ADDR_W-1:2], 2'b00}
                                            : {dstByte[ADDR_W-1:2], 2'b00};

  logic monoBit;
  logic [WORD_W-1:0] srcLane, dstLane, srcNext;

  assign monoBit = memRdata[{srcByte[1:0], xPos[2:0]}];
  assign srcLane = memRdata >> {srcByte[1:0], 3'b000};
  assign dstLane = memRdata >> {dstByte[1:0], 3'b000};
  assign srcNext = mono ? ((monoBit ? fg : bg) & pixMask) : (srcLane & pixMask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcPix <= '0;
      dstPix <= '0;
    end else begin
      if (dpCtrl.capSrc) srcPix <= srcNext;
      if (dpCtrl.capDst) dstPix <= dstLane & pixMask;
    end
  end

  logic patBit;
  logic [WORD_W-1:0] patPix, result;

  assign patBit = pat[{yPos[2:0], xPos[2:0]}];
  assign patPix = (patBit ? fg : bg) & pixMask;
  assign result = ropApply(rop, patPix, srcPix, dstPix) & pixMask;

  assign memWdata = result << {dstByte[1:0], 3'b000};
  assign memBe = (dpCtrl.phase == PH_WR) ? (beBase << dstByte[1:0]) : '1;
  assign skipWrite = transp && (srcPix == (key & pixMask));
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W = 12,
  parameter int PITCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  srcBase,
  input  logic [ADDR_W-1:0]  dstBase,
  input  logic [PITCH_W-1:0] srcPitch,
  input  logic [PITCH_W-1:0] dstPitch,
  input  logic [DIM_W-1:0]   width,
  input  logic [DIM_W-1:0]   height,
  input  logic [1:0]         depthSel,
  input  logic [7:0]         ropCode,
  input  logic               monoSrc,
  input  logic               transparent,
  input  logic [31:0]        fgColor,
  input  logic [31:0]        bgColor,
  input  logic [31:0]        keyColor,
  input  logic [63:0]        patBits,
  output logic               memValid,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [31:0]        memWdata,
  output logic [3:0]         memBe,
  input  logic               memReady,
  input  logic [31:0]        memRdata,
  output logic               busy,
  output logic               done
);
  dp_ctrl_t dpCtrl;
  logic [DIM_W-1:0] xPos, yPos;
  logic skipWrite;

  blit_ctrl #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .width(width), .height(height),
    .srcBase(srcBase), .dstBase(dstBase),
    .memReady(memReady), .skipWrite(skipWrite),
    .memValid(memValid), .memWe(memWe),
    .xPos(xPos), .yPos(yPos), .dpCtrl(dpCtrl),
    .busy(busy), .done(done)
  );

  blit_datapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PITCH_W(PITCH_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtrl(dpCtrl),
    .xPos(xPos), .yPos(yPos),
    .srcBase(srcBase), .dstBase(dstBase),
    .srcPitch(srcPitch), .dstPitch(dstPitch),
    .depthSel(depthSel), .ropCode(ropCode),
    .monoSrc(monoSrc), .transparent(transparent),
    .fgColor(fgColor), .bgColor(bgColor), .keyColor(keyColor),
    .patBits(patBits), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe),
    .skipWrite(skipWrite)
  );
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        memValid,
  input logic        memWe,
  input logic        memReady,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata,
  input logic [3:0]  memBe
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memWe) && $stable(memBe)); // R9

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && memWe && !memReady |=> $stable(memWdata)); // R9

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    memValid |-> memAddr[1:0] == 2'b00); // R9

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    memValid |-> ($countones(memBe) == 1 || $countones(memBe) == 2 || $countones(memBe) == 4)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memValid); // R7

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7

  AST_START_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy || done); // R8

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R7
endmodule

bind blit_engine blit_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .memValid(memValid), .memWe(memWe), .memReady(memReady),
  .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe)
);

// File: tb/blit_engine_bench.sv
module blit_engine_bench;
  localparam int MEM_WORDS = 256;
  localparam int MEM_BYTES = MEM_WORDS * 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start;
  logic [31:0] srcB, dstB;
  logic [15:0] srcP, dstP;
  logic [11:0] wd, ht;
  logic [1:0] dep;
  logic [7:0] rop;
  logic mono, transp;
  logic [31:0] fg, bg, key;
  logic [63:0] pat;
  logic memValid, memWe, memReady, busy, done;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0] memBe;

  blit_engine u_blit_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .srcBase(srcB), .dstBase(dstB), .srcPitch(srcP), .dstPitch(dstP),
    .width(wd), .height(ht), .depthSel(dep), .ropCode(rop),
    .monoSrc(mono), .transparent(transp),
    .fgColor(fg), .bgColor(bg), .keyColor(key), .patBits(pat),
    .memValid(memValid), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .memReady(memReady),
    .memRdata(memRdata), .busy(busy), .done(done)
  );

  logic [31:0] mem [MEM_WORDS];
  logic [7:0] gmem [MEM_BYTES];
  logic [7:0] lfsr;
  int accCnt = 0;
  int nCmp = 0;
  int nBad = 0;

  always @(posedge clk) begin
    if (!rst_n) lfsr <= 8'h5A;
    else lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end
  assign memReady = lfsr[0] | lfsr[3];
  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (memValid && memReady) begin
      accCnt <= accCnt + 1;
      if (memWe) begin
        for (int b = 0; b < 4; b++) begin
          if (memBe[b]) mem[memAddr[9:2]][8*b +: 8] <= memWdata[8*b +: 8];
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic initMem(input logic [31:0] seed);
    for (int i = 0; i < MEM_WORDS; i++) begin
      logic [31:0] v;
      v = (i * 32'h9E3779B1) ^ seed ^ (i << 13);
      mem[i] = v;
      for (int b = 0; b < 4; b++) gmem[4*i+b] = v[8*b +: 8];
    end
  endtask

  function automatic logic [31:0] gRd(input int a, input int nb);
    logic [31:0] v;
    v = '0;
    for (int b = 0; b < nb; b++) v[8*b +: 8] = gmem[a+b];
    return v;
  endfunction

  task automatic refRun(output int nWr);
    int sh, nb;
    logic [31:0] msk;
    bit rv;
    sh = (dep == 2'd0) ? 0 : (dep == 2'd1) ? 1 : 2;
    nb = 1 << sh;
    msk = (dep == 2'd0) ? 32'hFF : (dep == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    rv = dstB > srcB;
    nWr = 0;
    for (int k = 0; k < int'(ht); k++) begin
      for (int j = 0; j < int'(wd); j++) begin
        int yy, xx, sa, da;
        logic [31:0] sp, dp, pp, r;
        yy = rv ? int'(ht) - 1 - k : k;
        xx = rv ? int'(wd) - 1 - j : j;
        if (mono) begin
          sa = int'(srcB) + yy * int'(srcP) + xx / 8;
          sp = gmem[sa][xx % 8] ? fg : bg;
        end else begin
          sa = int'(srcB) + yy * int'(srcP) + xx * nb;
          sp = gRd(sa, nb);
        end
        sp = sp & msk;
        da = int'(dstB) + yy * int'(dstP) + xx * nb;
        dp = gRd(da, nb);
        pp = (pat[(yy % 8) * 8 + (xx % 8)] ? fg : bg) & msk;
        for (int i = 0; i < 32; i++) r[i] = rop[{pp[i], sp[i], dp[i]}];
        r = r & msk;
        if (!(transp && sp == (key & msk))) begin
          nWr++;
          for (int b = 0; b < nb; b++) gmem[da+b] = r[8*b +: 8];
        end
      end
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) check(tag, "done timeout", {31'd0, done}, 32'd1);
  endtask

  task automatic compareMem(input string tag);
    for (int i = 0; i < MEM_WORDS; i++) begin
      check(tag, $sformatf("word %0d", i), mem[i],
            {gmem[4*i+3], gmem[4*i+2], gmem[4*i+1], gmem[4*i]});
    end
  endtask

  task automatic runOp(input string tag);
    int nWr, acc0;
    refRun(nWr);
    acc0 = accCnt;
    pulseStart();
    check("R7", "busy after start", {31'd0, busy}, 32'd1);
    check("R7", "done cleared", {31'd0, done}, 32'd0);
    waitDone(tag);
    compareMem(tag);
    check("R9", "access count", accCnt - acc0, 2 * int'(wd) * int'(ht) + nWr);
  endtask

  task automatic setCfg(input logic [31:0] s, input logic [31:0] d, input logic [15:0] sp,
                        input logic [15:0] dp, input int w, input int h, input logic [1:0] dsel,
                        input logic [7:0] code);
    srcB = s; dstB = d; srcP = sp; dstP = dp;
    wd = 12'(w); ht = 12'(h); dep = dsel; rop = code;
    mono = 1'b0; transp = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL R7 watchdog: actual busy=%0d expected run complete", busy);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int acc0, nWr;
    rst_n = 1'b0; start = 1'b0;
    setCfg(32'h0, 32'h0, 16'd0, 16'd0, 0, 0, 2'd0, 8'h00);
    fg = 32'h1234_5678; bg = 32'h9ABC_DEF0; key = 32'h0; pat = 64'h0;
    initMem(32'h0BAD_F00D);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "reset busy", {31'd0, busy}, 32'd0);
    check("R7", "reset done", {31'd0, done}, 32'd0);
    check("R9", "reset memValid", {31'd0, memValid}, 32'd0);

    // R1: sweep every raster operation at 8-bit depth
    for (int c = 0; c < 256; c++) begin
      setCfg(32'h040, 32'h300, 16'd16, 16'd8, 3, 2, 2'd0, 8'(c));
      pat = 64'hA5C3_0F96_3C5A_E718 ^ {8{8'(c)}};
      fg = 32'h0000_00C6 ^ c; bg = 32'h0000_0039 ^ (c << 1);
      runOp("R1");
    end

    // R2: pattern copy across more than 8 columns and rows
    setCfg(32'h300, 32'h080, 16'd16, 16'd16, 10, 9, 2'd0, 8'hF0);
    pat = 64'h8142_2418_F00F_C3A5; fg = 32'h77; bg = 32'h11;
    runOp("R2");
    setCfg(32'h300, 32'h000, 16'd16, 16'd40, 9, 9, 2'd1, 8'h5A);
    pat = 64'h0123_4567_89AB_CDEF; fg = 32'hBEEF; bg = 32'h1357;
    runOp("R2");

    // R3: 16-bit and 32-bit depths, both lane positions
    setCfg(32'h200, 32'h012, 16'd20, 16'd12, 5, 3, 2'd1, 8'h66);
    runOp("R3");
    setCfg(32'h100, 32'h180, 16'd16, 16'd12, 3, 3, 2'd2, 8'hCC);
    runOp("R3");
    setCfg(32'h020, 32'h3A0, 16'd8, 16'd16, 2, 4, 2'd3, 8'h96);
    fg = 32'hCAFE_0001; bg = 32'h0F0F_F0F0;
    runOp("R3");

    // R4: monochrome source expanded at 16 and 32 bits
    setCfg(32'h2F1, 32'h040, 16'd2, 16'd32, 13, 3, 2'd1, 8'hCC);
    mono = 1'b1; fg = 32'h0000_ABCD; bg = 32'h0000_1234;
    runOp("R4");
    setCfg(32'h3F0, 32'h100, 16'd1, 16'd40, 7, 4, 2'd2, 8'hE2);
    mono = 1'b1; fg = 32'hDEAD_BEEF; bg = 32'h0102_0304; pat = 64'h55AA_55AA_33CC_33CC;
    runOp("R4");

    // R5: colour key on 8-bit copy, key equals a source pixel
    setCfg(32'h200, 32'h380, 16'd8, 16'd8, 8, 4, 2'd0, 8'hCC);
    transp = 1'b1; key = {24'h0, gmem[32'h200 + 1]};
    runOp("R5");
    // R5: mono source keyed on foreground, only background pixels written
    setCfg(32'h2C0, 32'h300, 16'd2, 16'd24, 11, 3, 2'd1, 8'hCC);
    mono = 1'b1; transp = 1'b1; fg = 32'h0000_4444; bg = 32'h0000_9999; key = 32'hFFFF_4444;
    runOp("R5");
    // R5: same source opaque writes every pixel
    setCfg(32'h2C0, 32'h300, 16'd2, 16'd24, 11, 3, 2'd1, 8'h3C);
    mono = 1'b1; key = 32'h4444;
    runOp("R5");

    // R6: overlapping rectangles in both directions
    setCfg(32'h100, 32'h111, 16'd16, 16'd16, 8, 4, 2'd0, 8'hCC);
    runOp("R6");
    setCfg(32'h123, 32'h100, 16'd16, 16'd16, 8, 4, 2'd0, 8'hCC);
    runOp("R6");
    setCfg(32'h100, 32'h104, 16'd16, 16'd16, 3, 3, 2'd2, 8'hCC);
    runOp("R6");
    setCfg(32'h084, 32'h080, 16'd16, 16'd16, 3, 3, 2'd1, 8'h6C);
    runOp("R6");

    // R8: zero width, then zero height
    for (int z = 0; z < 2; z++) begin
      setCfg(32'h000, 32'h100, 16'd4, 16'd4, (z == 0) ? 0 : 5, (z == 0) ? 3 : 0, 2'd0, 8'h00);
      acc0 = accCnt;
      pulseStart();
      check("R8", "done after empty start", {31'd0, done}, 32'd1);
      check("R8", "busy after empty start", {31'd0, busy}, 32'd0);
      @(negedge clk);
      check("R8", "no memory access", accCnt - acc0, 32'd0);
      compareMem("R8");
    end

    // R7: restart and input changes while busy are ignored
    setCfg(32'h200, 32'h240, 16'd8, 16'd8, 6, 4, 2'd0, 8'h99);
    refRun(nWr);
    acc0 = accCnt;
    pulseStart();
    repeat (6) @(negedge clk);
    setCfg(32'h000, 32'h000, 16'd4, 16'd4, 2, 2, 2'd2, 8'h00);
    pulseStart();
    fg = 32'h0; pat = 64'hFFFF_FFFF_FFFF_FFFF;
    waitDone("R7");
    compareMem("R7");
    check("R9", "access count", accCnt - acc0, 2 * 6 * 4 + nWr);
    repeat (3) @(negedge clk);
    check("R7", "done held", {31'd0, done}, 32'd1);
    check("R7", "idle after done", {31'd0, busy}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule